// File: doc/BRIEF.md
# Dual Reference Clock Switchover Controller

This block watches two reference clocks, A and B, and decides which one should drive a downstream PLL. Both references are brought into a free-running local clock domain through two-flop synchronizers. A rising-edge counter then decides, once per fixed window of local clocks, whether each reference is present. A state machine chooses the active reference and keeps the other as backup. It fails over automatically when the active reference is lost. When neither reference is usable it enters holdover and keeps the last selection. An input bit sets what happens when reference A recovers while B is active: stay on B, or revert to A.

A manual override forces the selection to either reference, even one that is absent. A one-cycle event pulse marks every change of the select output.

The state machine has five states:

| State | Meaning | `sel_b` |
|---|---|---|
| `ST_HOLD` | holdover | keeps its last value |
| `ST_AUTO_A` | automatic choice, reference A active | 0 |
| `ST_AUTO_B` | automatic choice, reference B active | 1 |
| `ST_FORCE_A` | manual override, reference A forced | 0 |
| `ST_FORCE_B` | manual override, reference B forced | 1 |

The transitions are:

- **Manual override.** Any state goes to `ST_FORCE_A` or `ST_FORCE_B` while `man_en` is 1, according to `man_sel`.
- **Leaving holdover.** `ST_HOLD` goes to `ST_AUTO_A` if A is present, else to `ST_AUTO_B` if B is present.
- **Leaving A.** `ST_AUTO_A` goes to `ST_AUTO_B` when A is lost and B is present. It goes to `ST_HOLD` when both are lost.
- **Leaving B.** `ST_AUTO_B` goes to `ST_AUTO_A` when B is lost and A is present. It also goes to `ST_AUTO_A` when both are present and `revert_a` is 1. It goes to `ST_HOLD` when both are lost.
- **Releasing the override.** `ST_FORCE_A` and `ST_FORCE_B` make the same choice as leaving holdover when `man_en` falls.

Top module: `refsw_ctrl`

## Requirements
- R1: A reference is flagged present (its `lost_*` output is 0) after a window of `WIN_CYCLES` local clocks in which at least `min_edges` of its rising edges were seen. It is flagged lost (`lost_*` = 1) after a window with fewer edges. References must be slower than half the local clock.
- R2: After reset, `sel_b` = 0, `holdover` = 1, `lost_a` = `lost_b` = 1 and `switch_evt` = 0.
- R3: If only one reference is present and the override is off, that reference becomes active (`sel_b` = 0 means A, 1 means B).
- R4: When both references become present together from holdover, A is chosen as active.
- R5: If the active reference is lost while the other is present, the other becomes active on the next local clock.
- R6: With B active and A present again, `revert_a` = 0 keeps B and `revert_a` = 1 moves to A.
- R7: When both references are lost with the override off, `holdover` = 1 and `sel_b` keeps its last value.
- R8: Leaving holdover selects A if A is present, otherwise B.
- R9: While `man_en` = 1, `sel_b` follows `man_sel` one local clock later, even when that reference is absent. In that case its `lost_*` bit stays 1 and `holdover` is 0.
- R10: `switch_evt` is 1 for exactly one local clock on each change of `sel_b`, and 0 at all other times.
- R11: When `man_en` returns to 0, the block picks A if present, otherwise B, otherwise holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running local clock |
| rst_n | input | 1 | asynchronous reset, active low |
| ref_a | input | 1 | reference clock A (asynchronous) |
| ref_b | input | 1 | reference clock B (asynchronous) |
| min_edges | input | CNT_W | minimum rising edges per window for presence |
| revert_a | input | 1 | 1: return to A when it recovers while B is active |
| man_en | input | 1 | manual override enable |
| man_sel | input | 1 | forced reference under override (0 = A, 1 = B) |
| sel_b | output | 1 | active reference select (0 = A, 1 = B) |
| holdover | output | 1 | 1 while no reference is in use |
| switch_evt | output | 1 | one-cycle pulse on each change of `sel_b` |
| lost_a | output | 1 | reference A failed its last window |
| lost_b | output | 1 | reference B failed its last window |

## Verification
The bench builds the block with `WIN_CYCLES` = 32 and `CNT_W` = 6, and sets `min_edges` to 3 at run time. The short window means every change in reference activity settles within a few hundred local clocks, so all failover, revert, holdover and override sequences fit in one short run. The bench drives references with periods of 6, 10 and 16 local clocks, which give about 5, 3.2 and 2 edges per window. That places one presence case exactly at the threshold and one just below it.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_AUTO_A  = 3'd1,
        ST_AUTO_B  = 3'd2,
        ST_FORCE_A = 3'd3,
        ST_FORCE_B = 3'd4
    } refsw_state_t;

    localparam int NUM_REFS = 2;

endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/refsw_presence.sv
module refsw_presence #(
    parameter int WIN_CYCLES = 256,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_s,
    input  logic [CNT_W-1:0] min_edges,
    output logic             present
);
    localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    logic             ref_d;
    logic             rise;
    logic [WIN_W-1:0] win_q;
    logic             win_end;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign rise    = ref_s & ~ref_d;
    assign win_end = (win_q == WIN_LAST);
    assign cnt_inc = (rise && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_d   <= 1'b0;
            win_q   <= '0;
            cnt_q   <= '0;
            present <= 1'b0;
        end else begin
            ref_d <= ref_s;
            if (win_end) begin
                win_q   <= '0;
                cnt_q   <= '0;
                present <= (cnt_inc >= min_edges);
            end else begin
                win_q <= win_q + 1'b1;
                cnt_q <= cnt_inc;
            end
        end
    end
endmodule

// File: rtl/refsw_fsm.sv
module refsw_fsm
    import refsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ok_a,
    input  logic ok_b,
    input  logic revert_a,
    input  logic man_en,
    input  logic man_sel,
    output logic sel_b,
    output logic holdover,
    output logic switch_evt
);
    refsw_state_t st_q, st_nxt;
    logic         sel_q, sel_nxt, evt_q;

    function automatic refsw_state_t pick(input logic a, input logic b);
        if (a)      return ST_AUTO_A;
        else if (b) return ST_AUTO_B;
        else        return ST_HOLD;
    endfunction

    always_comb begin
        st_nxt = st_q;
        if (man_en) begin
            st_nxt = man_sel ? ST_FORCE_B : ST_FORCE_A;
        end else begin
            unique case (st_q)
                ST_HOLD:    st_nxt = pick(ok_a, ok_b);
                ST_AUTO_A:  if (!ok_a) st_nxt = pick(1'b0, ok_b);
                ST_AUTO_B: begin
                    if (!ok_b)                 st_nxt = pick(ok_a, 1'b0);
                    else if (ok_a && revert_a) st_nxt = ST_AUTO_A;
                end
                ST_FORCE_A,
                ST_FORCE_B: st_nxt = pick(ok_a, ok_b);
                default:    st_nxt = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        unique case (st_nxt)
            ST_AUTO_A, ST_FORCE_A: sel_nxt = 1'b0;
            ST_AUTO_B, ST_FORCE_B: sel_nxt = 1'b1;
            default:               sel_nxt = sel_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            sel_q <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            sel_q <= sel_nxt;
            evt_q <= (sel_nxt != sel_q);
        end
    end

    always_comb begin
        sel_b      = sel_q;
        holdover   = (st_q == ST_HOLD);
        switch_evt = evt_q;
    end
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
    import refsw_pkg::*;
#(
    parameter int WIN_CYCLES = 256,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_a,
    input  logic             ref_b,
    input  logic [CNT_W-1:0] min_edges,
    input  logic             revert_a,
    input  logic             man_en,
    input  logic             man_sel,
    output logic             sel_b,
    output logic             holdover,
    output logic             switch_evt,
    output logic             lost_a,
    output logic             lost_b
);
    logic [NUM_REFS-1:0] ref_raw;
    logic [NUM_REFS-1:0] ref_s;
    logic [NUM_REFS-1:0] ok;

    assign ref_raw = {ref_b, ref_a};

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
        refsw_sync #(.STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ref_raw[i]),
            .q     (ref_s[i])
        );
        refsw_presence #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_s     (ref_s[i]),
            .min_edges (min_edges),
            .present   (ok[i])
        );
    end

    refsw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ok_a       (ok[0]),
        .ok_b       (ok[1]),
        .revert_a   (revert_a),
        .man_en     (man_en),
        .man_sel    (man_sel),
        .sel_b      (sel_b),
        .holdover   (holdover),
        .switch_evt (switch_evt)
    );

    assign lost_a = ~ok[0];
    assign lost_b = ~ok[1];
endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic man_en,
    input logic man_sel,
    input logic sel_b,
    input logic holdover,
    input logic switch_evt,
    input logic lost_a,
    input logic lost_b
);
    AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b != $past(sel_b)) == switch_evt);                                  // R10
    AST_HOLD_NEEDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        holdover |-> $past(lost_a && lost_b));                                   // R7
    AST_HOLD_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover && $past(holdover)) |-> $stable(sel_b));                       // R7
    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        man_en |=> (sel_b == $past(man_sel)));                                   // R9
    AST_FAILOVER_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_en && lost_a && !lost_b) |=> sel_b);                               // R5
    AST_FAILOVER_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_en && !lost_a && lost_b) |=> !sel_b);                              // R5
endmodule

bind refsw_ctrl refsw_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .man_en     (man_en),
    .man_sel    (man_sel),
    .sel_b      (sel_b),
    .holdover   (holdover),
    .switch_evt (switch_evt),
    .lost_a     (lost_a),
    .lost_b     (lost_b)
);

// File: tb/refsw_ctrl_test.sv
module refsw_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 32;
    localparam int CW         = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_a = 1'b0, ref_b = 1'b0;
    logic revert_a = 1'b0, man_en = 1'b0, man_sel = 1'b0;
    logic [CW-1:0] min_edges = CW'(3);
    logic sel_b, holdover, switch_evt, lost_a, lost_b;

    int half_a = 0, half_b = 0, ca = 0, cb = 0;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit exp_q[$];

    refsw_ctrl #(.WIN_CYCLES(WIN), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
        .min_edges(min_edges), .revert_a(revert_a), .man_en(man_en),
        .man_sel(man_sel), .sel_b(sel_b), .holdover(holdover),
        .switch_evt(switch_evt), .lost_a(lost_a), .lost_b(lost_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference generators, half periods counted in local clocks (0 = stopped)
    always @(negedge clk) begin
        if (half_a == 0) begin ref_a <= 1'b0; ca <= 0; end
        else if (ca + 1 >= half_a) begin ref_a <= ~ref_a; ca <= 0; end
        else ca <= ca + 1;
        if (half_b == 0) begin ref_b <= 1'b0; cb <= 0; end
        else if (cb + 1 >= half_b) begin ref_b <= ~ref_b; cb <= 0; end
        else cb <= cb + 1;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: expected select value after a switch
    task automatic expect_switch(input bit v);
        exp_q.push_back(v);
    endtask

    task automatic settle();
        repeat (4*WIN) @(negedge clk);
    endtask

    // monitor: each switch pulse pops one expected select value (R10)
    always @(negedge clk) begin
        if (rst_n && switch_evt && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected switch, actual sel_b %0b expected none", sel_b);
            end else begin
                if (sel_b !== exp_q[0]) begin
                    errors++;
                    $display("FAIL R10: switch sel_b actual %0b expected %0b", sel_b, exp_q[0]);
                end
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: missing switches actual 0 expected %0d", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset values
        chk("R2 sel_b", sel_b, 1'b0);
        chk("R2 holdover", holdover, 1'b1);
        chk("R2 lost_a", lost_a, 1'b1);
        chk("R2 lost_b", lost_b, 1'b1);
        chk("R2 switch_evt", switch_evt, 1'b0);
        rst_n = 1'b1;

        // R4 / R1: both appear together, A chosen, no switch
        half_a = 3; half_b = 3;
        settle();
        chk("R1 lost_a", lost_a, 1'b0);
        chk("R1 lost_b", lost_b, 1'b0);
        chk("R4 sel_b", sel_b, 1'b0);
        chk("R4 holdover", holdover, 1'b0);

        // R5: A fails, fail over to B
        expect_switch(1'b1);
        half_a = 0;
        settle();
        chk("R1 lost_a after stop", lost_a, 1'b1);
        chk("R5 sel_b", sel_b, 1'b1);

        // R6: A returns with revert_a = 0, stay on B
        half_a = 3;
        settle();
        chk("R6 lost_a", lost_a, 1'b0);
        chk("R6 stay on B", sel_b, 1'b1);

        // R6: revert_a = 1 moves to A
        expect_switch(1'b0);
        revert_a = 1'b1;
        settle();
        chk("R6 revert to A", sel_b, 1'b0);

        // R1 boundary: 2 edges per window < 3 -> lost
        expect_switch(1'b1);
        half_a = 8;
        settle();
        chk("R1 below threshold lost_a", lost_a, 1'b1);
        chk("R5 sel_b to B", sel_b, 1'b1);

        // R1 boundary: 3 or 4 edges per window -> present, revert to A
        expect_switch(1'b0);
        half_a = 5;
        settle();
        chk("R1 at threshold lost_a", lost_a, 1'b0);
        chk("R6 sel_b back to A", sel_b, 1'b0);

        // R7: lose B (backup), then A -> holdover, selection kept
        half_a = 3; half_b = 0;
        settle();
        chk("R1 lost_b", lost_b, 1'b1);
        chk("R5 A stays active", sel_b, 1'b0);
        half_a = 0;
        settle();
        chk("R7 holdover", holdover, 1'b1);
        chk("R7 sel_b kept", sel_b, 1'b0);

        // R8 / R3: only B returns -> B
        expect_switch(1'b1);
        revert_a = 1'b0;
        half_b = 3;
        settle();
        chk("R3 sel_b only B", sel_b, 1'b1);
        chk("R8 holdover left", holdover, 1'b0);

        // R8: back to holdover on B, then both return together -> A
        half_a = 0; half_b = 0;
        settle();
        chk("R7 holdover again", holdover, 1'b1);
        chk("R7 sel_b kept on B", sel_b, 1'b1);
        expect_switch(1'b0);
        half_a = 3; half_b = 3;
        settle();
        chk("R8 prefer A", sel_b, 1'b0);

        // R9: force an absent B
        half_b = 0;
        settle();
        expect_switch(1'b1);
        man_sel = 1'b1; man_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 forced B", sel_b, 1'b1);
        chk("R9 lost_b shown", lost_b, 1'b1);
        chk("R9 no holdover", holdover, 1'b0);
        expect_switch(1'b0);
        man_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 forced A", sel_b, 1'b0);

        // R11: release from forced B, A present -> A
        expect_switch(1'b1);
        man_sel = 1'b1;
        repeat (3) @(negedge clk);
        expect_switch(1'b0);
        man_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 release picks A", sel_b, 1'b0);
        chk("R11 no holdover", holdover, 1'b0);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule